// File: doc/BRIEF.md
# Dual-Index Conversion Result Bank

This block keeps the eight most recent 10-bit conversion results of an eight-step measurement sequence and presents them to a register-read path. The sequencer delivers each result as a stream beat carrying a slot number and a value. The bank stores the value in that slot unless the current sequence is a calibration run. In that case the beat is consumed and thrown away.

Two independent 3-bit read pointers choose which two stored results appear side by side in one read word. Software sets each pointer together with its own auto-step enable. When that enable is on, every read strobe advances the pointer by one after the read has been served, so that a run of reads walks through the bank.

The result input is a valid/ready stream that never applies back-pressure: ready is high in every cycle after reset, and a beat transfers on any cycle where valid is high. The read word is combinational. It is valid in the cycle of the read strobe and reflects the pointers and bank contents as they stood before that cycle's clock edge.

Top module: `adc_result_bank`

## Requirements
- R1: A result beat (res_valid high while res_ready is high) with cal_run low stores res_data in entry res_slot; the new value is readable from the next cycle.
- R2: rd_word[9:0] is the entry selected by pointer A and rd_word[19:10] is the entry selected by pointer B. Pointer B is the upper field.
- R3: A pointer write (ptrA_wr / ptrB_wr) loads that pointer's index and auto-step enable; both take effect in the next cycle.
- R4: When a pointer's auto-step enable is set, each rd_strobe advances it by one after the read, wrapping from 7 to 0. The word read in the strobe cycle uses the value from before the step.
- R5: The two pointers are independent. A pointer whose auto-step enable is clear holds its index across reads, whatever the other pointer does.
- R6: A pointer write in the same cycle as rd_strobe wins over the auto-step: the pointer takes the written index.
- R7: A result beat that arrives while cal_run is high leaves every entry unchanged.
- R8: After rst_n is released, all eight entries read as zero, both pointers are 0, and both auto-step enables are off.
- R9: res_ready is high in every cycle out of reset. A read of a slot in the same cycle as a beat writing that slot returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| res_valid | input | 1 | Result beat valid |
| res_ready | output | 1 | Result beat ready (no back-pressure) |
| res_slot | input | 3 | Slot number of the beat |
| res_data | input | 10 | Conversion value of the beat |
| cal_run | input | 1 | Current sequence is a calibration run |
| ptrA_wr | input | 1 | Load pointer A |
| ptrA_idx | input | 3 | New index for pointer A |
| ptrA_inc | input | 1 | New auto-step enable for pointer A |
| ptrB_wr | input | 1 | Load pointer B |
| ptrB_idx | input | 3 | New index for pointer B |
| ptrB_inc | input | 1 | New auto-step enable for pointer B |
| rd_strobe | input | 1 | Result register read |
| rd_word | output | 20 | {entry[B], entry[A]} |

## Verification
Two pairs of events can fall in the same cycle. The first is a software pointer load arriving with a read strobe while auto-step is on. The second is a result beat writing the very slot being read. The bench raises both signals on the same clock. It then judges the word read in that cycle against the pre-edge state, and the following read against the state that the stated priority gives (the written index, or the new data).

// File: rtl/adc_rb_pkg.sv
package adc_rb_pkg;
  localparam int unsigned DEF_DATA_W  = 10;
  localparam int unsigned DEF_ENTRIES = 8;

  typedef struct packed {
    logic       wr;
    logic [2:0] idx;
    logic       inc;
  } ptr_cmd_t;
endpackage

// File: rtl/adc_rb_bank.sv
module adc_rb_bank #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [IDX_W-1:0]          waddr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [ENTRIES*DATA_W-1:0] flat
);
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  q <= '0;
      else if (we && (waddr == IDX_W'(e)))         q <= wdata;
    end
    assign flat[e*DATA_W +: DATA_W] = q;
  end
endmodule

// File: rtl/adc_rb_ptr.sv
module adc_rb_ptr #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_inc,
  input  logic             rd,
  output logic [IDX_W-1:0] idx,
  output logic             inc_en
);
  logic [IDX_W-1:0] stepped;

  always_comb begin
    if (idx == IDX_W'(ENTRIES - 1)) stepped = '0;
    else                            stepped = idx + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx    <= '0;
      inc_en <= 1'b0;
    end else if (wr) begin
      idx    <= wr_idx;
      inc_en <= wr_inc;
    end else if (rd && inc_en) begin
      idx    <= stepped;
    end
  end
endmodule

// File: rtl/adc_rb_sel.sv
module adc_rb_sel #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*DATA_W-1:0] flat,
  input  logic [IDX_W-1:0]          sel,
  output logic [DATA_W-1:0]         dout
);
  always_comb begin
    dout = '0;
    for (int e = 0; e < ENTRIES; e++)
      if (sel == IDX_W'(e)) dout = flat[e*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank
  import adc_rb_pkg::*;
#(
  parameter int unsigned DATA_W  = DEF_DATA_W,
  parameter int unsigned ENTRIES = DEF_ENTRIES,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned NPTR   = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   res_valid,
  output logic                   res_ready,
  input  logic [IDX_W-1:0]       res_slot,
  input  logic [DATA_W-1:0]      res_data,
  input  logic                   cal_run,
  input  logic                   ptrA_wr,
  input  logic [IDX_W-1:0]       ptrA_idx,
  input  logic                   ptrA_inc,
  input  logic                   ptrB_wr,
  input  logic [IDX_W-1:0]       ptrB_idx,
  input  logic                   ptrB_inc,
  input  logic                   rd_strobe,
  output logic [NPTR*DATA_W-1:0] rd_word
);
  logic [ENTRIES*DATA_W-1:0] bank_flat;
  logic                      store;
  logic [NPTR-1:0]           p_wr;
  logic [NPTR-1:0]           p_inc_in;
  logic [IDX_W-1:0]          p_idx_in [NPTR];
  logic [IDX_W-1:0]          p_idx    [NPTR];
  logic [NPTR-1:0]           p_inc_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_ready <= 1'b0;
    else        res_ready <= 1'b1;
  end

  assign store = res_valid && res_ready && !cal_run;

  adc_rb_bank #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_bank (
    .clk(clk), .rst_n(rst_n), .we(store), .waddr(res_slot),
    .wdata(res_data), .flat(bank_flat)
  );

  assign p_wr        = {ptrB_wr, ptrA_wr};
  assign p_inc_in    = {ptrB_inc, ptrA_inc};
  assign p_idx_in[0] = ptrA_idx;
  assign p_idx_in[1] = ptrB_idx;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    adc_rb_ptr #(.ENTRIES(ENTRIES)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr(p_wr[p]), .wr_idx(p_idx_in[p]),
      .wr_inc(p_inc_in[p]), .rd(rd_strobe), .idx(p_idx[p]),
      .inc_en(p_inc_en[p])
    );
    adc_rb_sel #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_sel (
      .flat(bank_flat), .sel(p_idx[p]),
      .dout(rd_word[p*DATA_W +: DATA_W])
    );
  end
endmodule

// File: rtl/adc_result_bank_chk.sv
module adc_result_bank_chk #(
  parameter int unsigned DATA_W  = 10,
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      res_valid,
  input logic                      res_ready,
  input logic [IDX_W-1:0]          res_slot,
  input logic [DATA_W-1:0]         res_data,
  input logic                      cal_run,
  input logic                      ptrA_wr,
  input logic [IDX_W-1:0]          ptrA_idx,
  input logic                      ptrB_wr,
  input logic [IDX_W-1:0]          ptrB_idx,
  input logic                      rd_strobe,
  input logic [ENTRIES*DATA_W-1:0] bank_flat,
  input logic [IDX_W-1:0]          idx_a,
  input logic [IDX_W-1:0]          idx_b,
  input logic                      inc_a,
  input logic                      inc_b
);
  assert_store_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready && !cal_run) |=>
      bank_flat[$past(res_slot)*DATA_W +: DATA_W] == $past(res_data));

  assert_cal_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && cal_run) |=> $stable(bank_flat));

  assert_load_prio_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptrA_wr |=> idx_a == $past(ptrA_idx));

  assert_load_prio_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptrB_wr |=> idx_b == $past(ptrB_idx));

  assert_step_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && inc_a && !ptrA_wr) |=>
      idx_a == IDX_W'(($past(idx_a) + 1) % ENTRIES));

  assert_hold_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptrB_wr && !(rd_strobe && inc_b)) |=> $stable(idx_b));

  assert_hold_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptrA_wr && !(rd_strobe && inc_a)) |=> $stable(idx_a));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> res_ready);
endmodule

bind adc_result_bank adc_result_bank_chk #(.DATA_W(DATA_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
  .res_slot(res_slot), .res_data(res_data), .cal_run(cal_run),
  .ptrA_wr(ptrA_wr), .ptrA_idx(ptrA_idx), .ptrB_wr(ptrB_wr), .ptrB_idx(ptrB_idx),
  .rd_strobe(rd_strobe), .bank_flat(bank_flat),
  .idx_a(p_idx[0]), .idx_b(p_idx[1]), .inc_a(p_inc_en[0]), .inc_b(p_inc_en[1])
);

// File: tb/sim_adc_result_bank.sv
`timescale 1ns/1ps
module sim_adc_result_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0, cal_run = 1'b0, rd_strobe = 1'b0;
  logic [2:0] res_slot = '0;
  logic [9:0] res_data = '0;
  logic ptrA_wr = 1'b0, ptrA_inc = 1'b0, ptrB_wr = 1'b0, ptrB_inc = 1'b0;
  logic [2:0] ptrA_idx = '0, ptrB_idx = '0;
  logic res_ready;
  logic [19:0] rd_word;

  int checks = 0;
  int errors = 0;
  logic [9:0] model [8];

  always #2 clk = ~clk;

  adc_result_bank u0 (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_slot(res_slot), .res_data(res_data), .cal_run(cal_run),
    .ptrA_wr(ptrA_wr), .ptrA_idx(ptrA_idx), .ptrA_inc(ptrA_inc),
    .ptrB_wr(ptrB_wr), .ptrB_idx(ptrB_idx), .ptrB_inc(ptrB_inc),
    .rd_strobe(rd_strobe), .rd_word(rd_word)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [2:0] s, input logic [9:0] d, input logic cal);
    @(negedge clk);
    res_valid = 1'b1; res_slot = s; res_data = d; cal_run = cal;
    @(negedge clk);
    res_valid = 1'b0; cal_run = 1'b0;
  endtask

  task automatic set_ptrs(input logic [2:0] a, input logic ia, input logic [2:0] b, input logic ib);
    @(negedge clk);
    ptrA_wr = 1'b1; ptrA_idx = a; ptrA_inc = ia;
    ptrB_wr = 1'b1; ptrB_idx = b; ptrB_inc = ib;
    @(negedge clk);
    ptrA_wr = 1'b0; ptrB_wr = 1'b0;
  endtask

  // read strobe for one cycle; word checked mid-cycle before the edge
  task automatic rd(input string tag, input logic [9:0] ea, input logic [9:0] eb);
    @(negedge clk);
    rd_strobe = 1'b1;
    #1 chk(tag, {12'h0, rd_word}, {12'h0, eb, ea});
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  task automatic t_reset;
    #1 chk("R8 word zero after reset", {12'h0, rd_word}, 32'h0);
    chk("R9 ready high", {31'h0, res_ready}, 32'h1);
    rd("R8 read with default pointers", 10'h0, 10'h0);
    rd("R8 auto-step off by default", 10'h0, 10'h0);
  endtask

  task automatic t_fill;
    for (int i = 0; i < 8; i++) begin
      model[i] = 10'(10'h050 + i * 37);
      put(3'(i), model[i], 1'b0);
    end
    set_ptrs(3'd2, 1'b0, 3'd6, 1'b0);
    rd("R1 R2 R3 entries 2 and 6", model[2], model[6]);
    set_ptrs(3'd7, 1'b0, 3'd0, 1'b0);
    rd("R2 A=7 low field, B=0 high field", model[7], model[0]);
  endtask

  task automatic t_cal;
    put(3'd3, 10'h3FF, 1'b1);
    set_ptrs(3'd3, 1'b0, 3'd3, 1'b0);
    rd("R7 calibration beat dropped", model[3], model[3]);
  endtask

  task automatic t_step;
    set_ptrs(3'd6, 1'b1, 3'd1, 1'b0);
    rd("R4 first read before step", model[6], model[1]);
    rd("R4 R5 stepped A, held B", model[7], model[1]);
    rd("R4 wrap 7 to 0", model[0], model[1]);
    set_ptrs(3'd4, 1'b0, 3'd5, 1'b1);
    rd("R5 B steps alone", model[4], model[5]);
    rd("R5 A holds", model[4], model[6]);
  endtask

  task automatic t_prio;
    set_ptrs(3'd0, 1'b1, 3'd2, 1'b1);
    @(negedge clk);
    rd_strobe = 1'b1; ptrA_wr = 1'b1; ptrA_idx = 3'd5; ptrA_inc = 1'b1;
    #1 chk("R6 same-cycle read uses old pointers", {12'h0, rd_word}, {12'h0, model[2], model[0]});
    @(negedge clk);
    rd_strobe = 1'b0; ptrA_wr = 1'b0;
    #1 chk("R6 write beat auto-step", {12'h0, rd_word}, {12'h0, model[3], model[5]});
  endtask

  task automatic t_same_slot;
    set_ptrs(3'd4, 1'b0, 3'd1, 1'b0);
    @(negedge clk);
    rd_strobe = 1'b1; res_valid = 1'b1; res_slot = 3'd4; res_data = 10'h2A5;
    #1 chk("R9 same-slot read returns old", {12'h0, rd_word}, {12'h0, model[1], model[4]});
    @(negedge clk);
    rd_strobe = 1'b0; res_valid = 1'b0;
    model[4] = 10'h2A5;
    #1 chk("R1 R9 new value next cycle", {12'h0, rd_word}, {12'h0, model[1], model[4]});
    chk("R9 ready stays high", {31'h0, res_ready}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_cal();
    t_step();
    t_prio();
    t_same_slot();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule